// File: doc/BRIEF.md
# Pin Bank Restore Sequencer

This block brings one bank of general-purpose pins back to the state it held before a low-power period. The bank is reached through three registers: a mode word, a data word and a pull-up word. The block reaches them through a simple register master. A save operation reads the bank and keeps a private copy of its words. A later restore operation reads the mode word the bank holds at that moment. It then writes the kept words back in an order chosen so that no pin drives a stale or transient level.

The order is decided pin by pin. Some pins must take their new mode before the data word is written. Others must keep their old mode until the data word is in place. The block therefore writes an intermediate mode word first, then the data, then the full saved mode word, and last the pull-ups. A narrow variant serves banks that have one mode bit per pin and no pull-up register.

Top module: `pin_bank_restorer`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are all low, and `bus_req` stays low whenever `busy` is low.
- R2: A save reads the mode word (offset 0) and the data word (offset 1). In the wide variant it also reads the pull-up word (offset 2). The save writes nothing, and the values it reads are the ones a later restore writes back.
- R3: A restore begins with one read of the mode word at offset 0.
- R4: In the wide variant, pin p owns mode bits [2p+1:2p], coded as 0 input, 1 output, and 2 or 3 special function. The first write of a restore goes to offset 0. For a pin it carries the saved mode when the pin changes mode, is not switching between two special functions, and is not becoming an output. Otherwise it carries the mode just read back.
- R5: In the wide variant, the first write is followed by exactly three writes, in this order: the saved data word to offset 1, the saved mode word to offset 0, and the saved pull-up word to offset 2.
- R6: In the narrow variant (one bit per pin: 0 output, 1 special function), a restore writes the OR of the read-back and saved mode words to offset 0. It then writes the saved data to offset 1 and the saved mode word to offset 0. Neither operation ever addresses offset 2.
- R7: Every transfer keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ready` is seen high at a clock edge. Each transfer is issued only after the one before it has been accepted.
- R8: `done` is high for exactly one cycle: the cycle that follows the clock edge accepting the final transfer of an operation. `busy` is low again in that same cycle.
- R9: A start request raised while an operation is in progress is ignored.
- R10: When `start_save` and `start_restore` are raised together while idle, only the save is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_save | input | 1 | Request to capture the bank's words |
| start_restore | input | 1 | Request to write the captured words back |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| bus_req | output | 1 | Transfer request to the bank registers |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register offset (mode 0, data 1, pull-up 2 by default) |
| bus_wdata | output | W | Write data (W = PINS x bits per pin) |
| bus_rdata | input | W | Read data, valid in the cycle `bus_ready` is high |
| bus_ready | input | 1 | Transfer accepted at this clock edge |

## Verification
Two functions can meet in one cycle. The first is a start request arriving together with another start, or while a transfer is still in flight. The second is the per-pin ordering decision, which is taken from read data in the very cycle that read is accepted. The bench raises both start inputs together on an idle block. It also pulses both starts in the middle of a restore with wait states applied. In each case it judges the result from the complete logged transfer sequence and from the bank contents that follow. The ordering decision is swept over all sixteen old/new mode pairs at every pin position, with zero, one and two wait states per transfer.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  // one-hot state indices
  localparam int ST_IDLE    = 0;
  localparam int ST_SV_CFG  = 1;
  localparam int ST_SV_DAT  = 2;
  localparam int ST_SV_PUP  = 3;
  localparam int ST_RS_RD   = 4;
  localparam int ST_RS_CFG1 = 5;
  localparam int ST_RS_DAT  = 6;
  localparam int ST_RS_CFG2 = 7;
  localparam int ST_RS_PUP  = 8;
  localparam int ST_COUNT   = 9;

  typedef logic [ST_COUNT-1:0] st_vec_t;

  localparam logic [1:0] MODE_IN  = 2'd0;
  localparam logic [1:0] MODE_OUT = 2'd1;

  function automatic st_vec_t st_bit(input int idx);
    st_vec_t v;
    v      = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic mode_is_sfn(input logic [1:0] m);
    return m[1];
  endfunction

  // pin takes its saved mode in the early mode write
  function automatic logic early_apply(input logic [1:0] was, input logic [1:0] want);
    return (was != want) && !(mode_is_sfn(was) && mode_is_sfn(want)) && (want != MODE_OUT);
  endfunction

endpackage

// File: rtl/pbr_pin_rule.sv
module pbr_pin_rule #(
  parameter int PINS = 16,
  parameter bit WIDE = 1'b1,
  localparam int W = PINS * (WIDE ? 2 : 1)
) (
  input  logic [W-1:0] old_cfg,
  input  logic [W-1:0] new_cfg,
  output logic [W-1:0] first_cfg
);
  import pbr_pkg::*;

  generate
    if (WIDE) begin : g_wide
      for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic take_new;
        assign take_new          = early_apply(old_cfg[2*p +: 2], new_cfg[2*p +: 2]);
        assign first_cfg[2*p +: 2] = take_new ? new_cfg[2*p +: 2] : old_cfg[2*p +: 2];
      end
    end else begin : g_narrow
      // every pin headed for special function gets there before data moves
      assign first_cfg = old_cfg | new_cfg;
    end
  endgenerate

endmodule

// File: rtl/pbr_snapshot.sv
module pbr_snapshot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_cfg,
  input  logic         ld_dat,
  input  logic         ld_pup,
  input  logic [W-1:0] din,
  output logic [W-1:0] sv_cfg,
  output logic [W-1:0] sv_dat,
  output logic [W-1:0] sv_pup
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sv_cfg <= '0;
      sv_dat <= '0;
      sv_pup <= '0;
    end else begin
      if (ld_cfg) sv_cfg <= din;
      if (ld_dat) sv_dat <= din;
      if (ld_pup) sv_pup <= din;
    end
  end

endmodule

// File: rtl/pbr_seq.sv
module pbr_seq #(
  parameter int W  = 32,
  parameter bit WIDE = 1'b1,
  parameter int AW = 4,
  parameter logic [AW-1:0] OFS_CFG = 'd0,
  parameter logic [AW-1:0] OFS_DAT = 'd1,
  parameter logic [AW-1:0] OFS_PUP = 'd2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_save,
  input  logic          start_restore,
  input  logic          bus_ready,
  input  logic [W-1:0]  first_cfg,
  input  logic [W-1:0]  sv_cfg,
  input  logic [W-1:0]  sv_dat,
  input  logic [W-1:0]  sv_pup,
  output logic          ld_cfg,
  output logic          ld_dat,
  output logic          ld_pup,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [W-1:0]  bus_wdata,
  output logic          busy,
  output logic          done
);
  import pbr_pkg::*;

  st_vec_t        st_q, nxt_st;
  logic           req_q, nxt_req;
  logic           we_q, nxt_we;
  logic [AW-1:0]  addr_q, nxt_addr;
  logic [W-1:0]   wdata_q, nxt_wdata;
  logic           done_q, nxt_done;
  logic           accept;

  assign accept = req_q && bus_ready;
  assign ld_cfg = st_q[ST_SV_CFG] && accept;
  assign ld_dat = st_q[ST_SV_DAT] && accept;
  assign ld_pup = st_q[ST_SV_PUP] && accept;

  always_comb begin
    nxt_st    = st_q;
    nxt_req   = req_q;
    nxt_we    = we_q;
    nxt_addr  = addr_q;
    nxt_wdata = wdata_q;
    nxt_done  = 1'b0;
    if (st_q[ST_IDLE]) begin
      if (start_save) begin
        nxt_st = st_bit(ST_SV_CFG); nxt_req = 1'b1; nxt_we = 1'b0; nxt_addr = OFS_CFG;
      end else if (start_restore) begin
        nxt_st = st_bit(ST_RS_RD);  nxt_req = 1'b1; nxt_we = 1'b0; nxt_addr = OFS_CFG;
      end
    end else if (accept) begin
      if (st_q[ST_SV_CFG]) begin
        nxt_st = st_bit(ST_SV_DAT); nxt_we = 1'b0; nxt_addr = OFS_DAT;
      end else if (st_q[ST_SV_DAT] && WIDE) begin
        nxt_st = st_bit(ST_SV_PUP); nxt_we = 1'b0; nxt_addr = OFS_PUP;
      end else if (st_q[ST_RS_RD]) begin
        nxt_st = st_bit(ST_RS_CFG1); nxt_we = 1'b1; nxt_addr = OFS_CFG; nxt_wdata = first_cfg;
      end else if (st_q[ST_RS_CFG1]) begin
        nxt_st = st_bit(ST_RS_DAT);  nxt_we = 1'b1; nxt_addr = OFS_DAT; nxt_wdata = sv_dat;
      end else if (st_q[ST_RS_DAT]) begin
        nxt_st = st_bit(ST_RS_CFG2); nxt_we = 1'b1; nxt_addr = OFS_CFG; nxt_wdata = sv_cfg;
      end else if (st_q[ST_RS_CFG2] && WIDE) begin
        nxt_st = st_bit(ST_RS_PUP);  nxt_we = 1'b1; nxt_addr = OFS_PUP; nxt_wdata = sv_pup;
      end else begin
        nxt_st   = st_bit(ST_IDLE);
        nxt_req  = 1'b0;
        nxt_we   = 1'b0;
        nxt_done = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= st_bit(ST_IDLE);
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= nxt_st;
      req_q   <= nxt_req;
      we_q    <= nxt_we;
      addr_q  <= nxt_addr;
      wdata_q <= nxt_wdata;
      done_q  <= nxt_done;
    end
  end

  assign bus_req   = req_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign busy      = ~st_q[ST_IDLE];
  assign done      = done_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);

  assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_req && bus_ready));

  assert_state_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(st_q) == 1);

  generate
    if (!WIDE) begin : g_narrow_chk
      assert_no_pullup_access_R6: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_addr != OFS_PUP));
    end
  endgenerate

endmodule

// File: rtl/pin_bank_restorer.sv
module pin_bank_restorer #(
  parameter int PINS = 16,
  parameter bit WIDE = 1'b1,
  parameter int AW   = 4,
  parameter logic [AW-1:0] OFS_CFG = 'd0,
  parameter logic [AW-1:0] OFS_DAT = 'd1,
  parameter logic [AW-1:0] OFS_PUP = 'd2,
  localparam int W = PINS * (WIDE ? 2 : 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_save,
  input  logic          start_restore,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  bus_rdata,
  input  logic          bus_ready
);

  logic [W-1:0] first_cfg, sv_cfg, sv_dat, sv_pup;
  logic         ld_cfg, ld_dat, ld_pup;

  pbr_pin_rule #(.PINS(PINS), .WIDE(WIDE)) u_rule (
    .old_cfg   (bus_rdata),
    .new_cfg   (sv_cfg),
    .first_cfg (first_cfg)
  );

  pbr_snapshot #(.W(W)) u_snap (
    .clk    (clk),
    .rst    (rst),
    .ld_cfg (ld_cfg),
    .ld_dat (ld_dat),
    .ld_pup (ld_pup),
    .din    (bus_rdata),
    .sv_cfg (sv_cfg),
    .sv_dat (sv_dat),
    .sv_pup (sv_pup)
  );

  pbr_seq #(
    .W(W), .WIDE(WIDE), .AW(AW),
    .OFS_CFG(OFS_CFG), .OFS_DAT(OFS_DAT), .OFS_PUP(OFS_PUP)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_save    (start_save),
    .start_restore (start_restore),
    .bus_ready     (bus_ready),
    .first_cfg     (first_cfg),
    .sv_cfg        (sv_cfg),
    .sv_dat        (sv_dat),
    .sv_pup        (sv_pup),
    .ld_cfg        (ld_cfg),
    .ld_dat        (ld_dat),
    .ld_pup        (ld_pup),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .busy          (busy),
    .done          (done)
  );

  // a pull-up capture never happens outside a save in the wide variant
  assert_pup_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ld_pup |-> (WIDE && busy && !bus_we));

endmodule

// File: tb/sim_pin_bank_restorer.sv
module sim_bank_port #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          ready,
  input  int            wait_n,
  input  logic          preset,
  input  logic          clr_log,
  input  logic [W-1:0]  p_cfg,
  input  logic [W-1:0]  p_dat,
  input  logic [W-1:0]  p_pup
);
  logic [W-1:0]  r_cfg = '0, r_dat = '0, r_pup = '0;
  int            cnt = 0, cyc = 0, last_acc = 0, log_n = 0;
  logic [AW-1:0] log_addr [16];
  logic          log_we   [16];
  logic [W-1:0]  log_data [16];

  assign ready = req && (cnt >= wait_n);
  assign rdata = (addr == 0) ? r_cfg : (addr == 1) ? r_dat : (addr == 2) ? r_pup : '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (preset) begin
      r_cfg <= p_cfg; r_dat <= p_dat; r_pup <= p_pup;
    end
    if (clr_log) log_n <= 0;
    if (req) begin
      if (ready) begin
        cnt      <= 0;
        last_acc <= cyc;
        if (log_n < 16) begin
          log_addr[log_n] <= addr;
          log_we[log_n]   <= we;
          log_data[log_n] <= wdata;
          log_n           <= log_n + 1;
        end
        if (we) begin
          if (addr == 0) r_cfg <= wdata;
          if (addr == 1) r_dat <= wdata;
          if (addr == 2) r_pup <= wdata;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      cnt <= 0;
    end
  end
endmodule

module sim_pin_bank_restorer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // wide instance
  logic        sv0 = 0, rs0 = 0, busy0, done0, req0, we0, rdy0;
  logic [3:0]  addr0;
  logic [31:0] wd0, rd0;
  int          wait0 = 0;
  logic        pre0 = 0, clr0 = 0;
  logic [31:0] pc0 = 0, pd0 = 0, pp0 = 0;

  // narrow instance
  logic        sv1 = 0, rs1 = 0, busy1, done1, req1, we1, rdy1;
  logic [3:0]  addr1;
  logic [15:0] wd1, rd1;
  int          wait1 = 0;
  logic        pre1 = 0, clr1 = 0;
  logic [15:0] pc1 = 0, pd1 = 0, pp1 = 0;

  pin_bank_restorer #(.PINS(16), .WIDE(1'b1)) u0 (
    .clk(clk), .rst(rst), .start_save(sv0), .start_restore(rs0), .busy(busy0), .done(done0),
    .bus_req(req0), .bus_we(we0), .bus_addr(addr0), .bus_wdata(wd0), .bus_rdata(rd0), .bus_ready(rdy0));

  sim_bank_port #(.W(32), .AW(4)) m0 (
    .clk(clk), .req(req0), .we(we0), .addr(addr0), .wdata(wd0), .rdata(rd0), .ready(rdy0),
    .wait_n(wait0), .preset(pre0), .clr_log(clr0), .p_cfg(pc0), .p_dat(pd0), .p_pup(pp0));

  pin_bank_restorer #(.PINS(16), .WIDE(1'b0)) u1 (
    .clk(clk), .rst(rst), .start_save(sv1), .start_restore(rs1), .busy(busy1), .done(done1),
    .bus_req(req1), .bus_we(we1), .bus_addr(addr1), .bus_wdata(wd1), .bus_rdata(rd1), .bus_ready(rdy1));

  sim_bank_port #(.W(16), .AW(4)) m1 (
    .clk(clk), .req(req1), .we(we1), .addr(addr1), .wdata(wd1), .rdata(rd1), .ready(rdy1),
    .wait_n(wait1), .preset(pre1), .clr_log(clr1), .p_cfg(pc1), .p_dat(pd1), .p_pup(pp1));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_first(input logic [31:0] o, input logic [31:0] n);
    logic [31:0] r;
    logic [1:0]  a, b;
    bit          e;
    for (int p = 0; p < 16; p++) begin
      a = o[2*p +: 2];
      b = n[2*p +: 2];
      e = (a != b) && !(a >= 2'd2 && b >= 2'd2) && (b != 2'd1);
      r[2*p +: 2] = e ? b : a;
    end
    return r;
  endfunction

  task automatic prep0(input bit load, input logic [31:0] c, input logic [31:0] d, input logic [31:0] p);
    @(negedge clk); pre0 = load; clr0 = 1; pc0 = c; pd0 = d; pp0 = p;
    @(negedge clk); pre0 = 0; clr0 = 0;
  endtask

  task automatic prep1(input bit load, input logic [15:0] c, input logic [15:0] d, input logic [15:0] p);
    @(negedge clk); pre1 = load; clr1 = 1; pc1 = c; pd1 = d; pp1 = p;
    @(negedge clk); pre1 = 0; clr1 = 0;
  endtask

  task automatic go0(input bit s, input bit r);
    @(negedge clk); sv0 = s; rs0 = r;
    @(negedge clk); sv0 = 0; rs0 = 0;
  endtask

  task automatic go1(input bit s, input bit r);
    @(negedge clk); sv1 = s; rs1 = r;
    @(negedge clk); sv1 = 0; rs1 = 0;
  endtask

  task automatic wait_done0(input string tag);
    bit seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done0) seen = 1; else @(negedge clk);
    end
    chk(seen, tag, "wide done seen", 32'(seen), 1);
    if (seen) begin
      chk(m0.cyc == m0.last_acc + 1, "R8", "wide done follows final accept", m0.cyc, m0.last_acc + 1);
      chk(!busy0, "R8", "wide busy low with done", 32'(busy0), 0);
      @(negedge clk);
      chk(!done0, "R8", "wide done one cycle", 32'(done0), 0);
    end
  endtask

  task automatic wait_done1(input string tag);
    bit seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done1) seen = 1; else @(negedge clk);
    end
    chk(seen, tag, "narrow done seen", 32'(seen), 1);
    if (seen) begin
      chk(m1.cyc == m1.last_acc + 1, "R8", "narrow done follows final accept", m1.cyc, m1.last_acc + 1);
      @(negedge clk);
      chk(!done1, "R8", "narrow done one cycle", 32'(done1), 0);
    end
  endtask

  task automatic ent0(input int i, input bit we, input logic [3:0] a, input logic [31:0] d,
                      input bit cmpd, input string tag);
    chk(m0.log_we[i] == we && m0.log_addr[i] == a, tag, $sformatf("wide entry %0d we/addr", i),
        {m0.log_we[i], 27'd0, m0.log_addr[i]}, {we, 27'd0, a});
    if (cmpd) chk(m0.log_data[i] == d, tag, $sformatf("wide entry %0d data", i), m0.log_data[i], d);
  endtask

  task automatic ent1(input int i, input bit we, input logic [3:0] a, input logic [15:0] d,
                      input bit cmpd, input string tag);
    chk(m1.log_we[i] == we && m1.log_addr[i] == a, tag, $sformatf("narrow entry %0d we/addr", i),
        {m1.log_we[i], 27'd0, m1.log_addr[i]}, {we, 27'd0, a});
    if (cmpd) chk(m1.log_data[i] == d, tag, $sformatf("narrow entry %0d data", i), 32'(m1.log_data[i]), 32'(d));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] oc, nc, dd, pu;
    logic [15:0] o1, n1, d1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy0 && !done0 && !req0, "R1", "wide idle after reset", {busy0, done0, req0}, 0);
    chk(!busy1 && !done1 && !req1, "R1", "narrow idle after reset", {busy1, done1, req1}, 0);

    // wide sweep: pin i carries old/new pair (i+s)%16
    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < 16; i++) begin
        int k = (i + s) % 16;
        oc[2*i +: 2] = 2'(k >> 2);
        nc[2*i +: 2] = 2'(k);
      end
      dd = 32'h1357_9BDF ^ (32'(s) * 32'h0101_0101);
      pu = dd ^ 32'hF0F0_0F0F;
      wait0 = s % 3;
      prep0(1, nc, dd, pu);
      go0(1, 0);
      wait_done0("R2");
      chk(m0.log_n == 3, (s % 3 != 0) ? "R7" : "R2", "save transfer count", m0.log_n, 3);
      ent0(0, 0, 4'd0, 0, 0, "R2");
      ent0(1, 0, 4'd1, 0, 0, "R2");
      ent0(2, 0, 4'd2, 0, 0, "R2");
      prep0(1, oc, ~dd, 32'h0);
      go0(0, 1);
      if (s == 5) go0(1, 1); // R9: starts while restore in flight
      wait_done0("R5");
      repeat (4) @(negedge clk);
      chk(m0.log_n == 5, (s == 5) ? "R9" : "R7", "restore transfer count", m0.log_n, 5);
      ent0(0, 0, 4'd0, 0, 0, "R3");
      ent0(1, 1, 4'd0, exp_first(oc, nc), 1, "R4");
      ent0(2, 1, 4'd1, dd, 1, "R5");
      ent0(3, 1, 4'd0, nc, 1, "R5");
      ent0(4, 1, 4'd2, pu, 1, "R5");
      chk(m0.r_cfg == nc && m0.r_dat == dd && m0.r_pup == pu, "R2", "bank restored",
          m0.r_cfg ^ m0.r_dat ^ m0.r_pup, nc ^ dd ^ pu);
    end

    // R10: both starts together while idle -> save only
    wait0 = 1;
    prep0(1, 32'hA5A5_0F0F, 32'h0BAD_F00D, 32'h7777_1111);
    go0(1, 1);
    wait_done0("R10");
    repeat (3) @(negedge clk);
    chk(m0.log_n == 3, "R10", "simultaneous start transfer count", m0.log_n, 3);
    chk(!m0.log_we[0] && !m0.log_we[1] && !m0.log_we[2], "R10", "simultaneous start no writes",
        {m0.log_we[0], m0.log_we[1], m0.log_we[2]}, 0);
    prep0(1, 32'h0, 32'h0, 32'h0);
    go0(0, 1);
    wait_done0("R10");
    chk(m0.r_cfg == 32'hA5A5_0F0F && m0.r_dat == 32'h0BAD_F00D && m0.r_pup == 32'h7777_1111,
        "R10", "save values from simultaneous start restored", m0.r_dat, 32'h0BAD_F00D);

    // narrow variant
    for (int s = 0; s < 6; s++) begin
      o1 = 16'h5A3C ^ (16'(s) * 16'h1111);
      n1 = 16'hC30F ^ (16'(s) * 16'h0F21);
      d1 = 16'h9E37 + 16'(s);
      wait1 = s % 3;
      prep1(1, n1, d1, 16'hBEEF);
      go1(1, 0);
      wait_done1("R6");
      chk(m1.log_n == 2, "R6", "narrow save transfer count", m1.log_n, 2);
      ent1(0, 0, 4'd0, 0, 0, "R6");
      ent1(1, 0, 4'd1, 0, 0, "R6");
      prep1(1, o1, ~d1, 16'hBEEF);
      go1(0, 1);
      wait_done1("R6");
      chk(m1.log_n == 4, "R6", "narrow restore transfer count", m1.log_n, 4);
      ent1(0, 0, 4'd0, 0, 0, "R3");
      ent1(1, 1, 4'd0, o1 | n1, 1, "R6");
      ent1(2, 1, 4'd1, d1, 1, "R6");
      ent1(3, 1, 4'd0, n1, 1, "R6");
      chk(m1.r_pup == 16'hBEEF, "R6", "narrow pull-up untouched", 32'(m1.r_pup), 32'hBEEF);
      chk(m1.r_cfg == n1 && m1.r_dat == d1, "R6", "narrow bank restored", 32'(m1.r_cfg), 32'(n1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule